// File: doc/BRIEF.md
# Sample FIFO Bank with Sticky Underflow Status

This block holds a bank of independent sample FIFOs, one for each sample sequencer, each with its own push port on the producer side and its own pop port for the host. Read data is registered and appears one cycle after a pop request. A host pop made while the selected FIFO is empty does no harm. It leaves both pointers where they are, returns zero data and records the event in a sticky per-FIFO flag.

The flags sit at the low end of a 32-bit status word. The host reads that word, and clears chosen flags by writing ones, through a small synchronous register port with one cycle of read latency. The status word sits at one address. Every other address reads as zero.

Top module: `smp_uflow_top`

## Requirements
- R1: Each of the four FIFOs holds up to 8 entries of 10 bits and returns them in push order. A pop of a non-empty FIFO places its head entry on that FIFO's `pop_data` slice in the next cycle, and the slice holds its value while no pop is requested.
- R2: `full[n]` is high when FIFO n holds 8 entries and `empty[n]` is high when it holds none. A push into a full FIFO is dropped and its contents stay as they were. When a full FIFO sees a push and a pop in the same cycle, the pop is served and the push is dropped.
- R3: A pop request on an empty FIFO n sets status bit n in the cycle after the request.
- R4: A pop that underflows sets that FIFO's `pop_data` slice to all zeros in the next cycle.
- R5: A pop that underflows moves neither pointer. Data pushed afterwards comes out in order and is not lost or duplicated, and the FIFO stays empty unless a push arrives in the same cycle.
- R6: A set flag stays set through further underflows and through normal pops until it is cleared.
- R7: A write to the status address clears each flag whose bit is 1 in `reg_wdata`. A 0 bit leaves its flag unchanged.
- R8: When an underflow and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R9: The status word sits at address 0. Bit n is the flag of FIFO n, and bits 31:4 read as zero and ignore writes. Any other address reads as zero, and a write to it has no effect.
- R10: After reset all flags are 0, every FIFO is empty and not full, and `pop_data` and `reg_rdata` are zero.
- R11: `reg_rdata` presents, one cycle after the address is applied, the status word as it stood in the cycle the address was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 4 | Push strobe per FIFO |
| push_data | input | 40 | Push data, FIFO n in bits 10n+9:10n |
| pop_req | input | 4 | Pop request per FIFO |
| pop_data | output | 40 | Registered pop data, FIFO n in bits 10n+9:10n |
| full | output | 4 | FIFO n holds 8 entries |
| empty | output | 4 | FIFO n holds no entries |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data (ones clear flags) |
| reg_rdata | output | 32 | Registered read data |

## Verification
Assertions check the following on every cycle. An underflow event sets its flag and zeroes its data slice in the next cycle. A flag holds unless a clear bit hits it, and it drops after a clear when no underflow coincides. An underflowing pop without a push leaves the FIFO empty. Full and empty are never high together, and the reserved read bits stay zero. Only the bench scenarios can show that data survives an underflow in order, that an overfilled FIFO drops exactly the surplus, that a write of 0 or a write to the reserved bits leaves the word unchanged, and that the read data lines up with the cycle in which the address was applied. The bench compares every output on every cycle against its own model.

// File: rtl/smp_uflow_pkg.sv
package smp_uflow_pkg;
  localparam int unsigned STAT_W = 32;
  typedef logic [STAT_W-1:0] stat_word_t;

  // flag update rule: a set request dominates a clear request on the same bit
  function automatic stat_word_t sticky_update(input stat_word_t cur,
                                               input stat_word_t set_m,
                                               input stat_word_t clr_m);
    return set_m | (cur & ~clr_m);
  endfunction
endpackage

// File: rtl/smp_fifo.sv
module smp_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] pop_data,
  output logic          full,
  output logic          empty,
  output logic          uflow,
  output logic          push_acc,
  output logic          pop_acc
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign push_acc = push_valid & ~full;
  assign pop_acc  = pop_req & ~empty;
  assign uflow    = pop_req & empty;

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      pop_data <= '0;
    end else begin
      if (push_acc) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (pop_acc)  rd_ptr_q <= ptr_step(rd_ptr_q);
      case ({push_acc, pop_acc})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (pop_acc)    pop_data <= mem[rd_ptr_q];
      else if (uflow) pop_data <= '0;
    end
  end
endmodule

// File: rtl/smp_uflow_stat.sv
module smp_uflow_stat
  import smp_uflow_pkg::*;
#(
  parameter int unsigned NUM_Q     = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_Q-1:0]  uflow_set,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  stat_word_t        reg_wdata,
  output logic [NUM_Q-1:0]  flags,
  output logic [NUM_Q-1:0]  clr_mask,
  output stat_word_t        reg_rdata
);
  logic       hit;
  stat_word_t cur_w, set_w, clr_w, nxt_w, rd_w;

  assign hit = (reg_addr == STAT_ADDR);

  always_comb begin
    cur_w = '0;
    set_w = '0;
    clr_w = '0;
    cur_w[NUM_Q-1:0] = flags;
    set_w[NUM_Q-1:0] = uflow_set;
    if (reg_wr && hit) clr_w[NUM_Q-1:0] = reg_wdata[NUM_Q-1:0];
    nxt_w = sticky_update(cur_w, set_w, clr_w);
    rd_w  = hit ? cur_w : '0;
  end

  assign clr_mask = clr_w[NUM_Q-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      reg_rdata <= '0;
    end else begin
      flags     <= nxt_w[NUM_Q-1:0];
      reg_rdata <= rd_w;
    end
  end
endmodule

// File: rtl/smp_uflow_top.sv
module smp_uflow_top
  import smp_uflow_pkg::*;
#(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DW     = 10,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_Q-1:0]    push_valid,
  input  logic [NUM_Q*DW-1:0] push_data,
  input  logic [NUM_Q-1:0]    pop_req,
  output logic [NUM_Q*DW-1:0] pop_data,
  output logic [NUM_Q-1:0]    full,
  output logic [NUM_Q-1:0]    empty,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [STAT_W-1:0]   reg_wdata,
  output logic [STAT_W-1:0]   reg_rdata
);
  logic [NUM_Q-1:0] uflow_evt;
  logic [NUM_Q-1:0] push_acc;
  logic [NUM_Q-1:0] pop_acc;
  logic [NUM_Q-1:0] stat_flags;
  logic [NUM_Q-1:0] clr_mask;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    smp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_valid(push_valid[q]),
      .push_data (push_data[q*DW +: DW]),
      .pop_req   (pop_req[q]),
      .pop_data  (pop_data[q*DW +: DW]),
      .full      (full[q]),
      .empty     (empty[q]),
      .uflow     (uflow_evt[q]),
      .push_acc  (push_acc[q]),
      .pop_acc   (pop_acc[q])
    );
  end

  smp_uflow_stat #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .STAT_ADDR('0)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .uflow_set(uflow_evt),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .flags    (stat_flags),
    .clr_mask (clr_mask),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/smp_uflow_chk.sv
module smp_uflow_chk #(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned DW    = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_Q-1:0]    push_valid,
  input logic [NUM_Q-1:0]    pop_req,
  input logic [NUM_Q*DW-1:0] pop_data,
  input logic [NUM_Q-1:0]    full,
  input logic [NUM_Q-1:0]    empty,
  input logic [31:0]         reg_rdata,
  input logic [NUM_Q-1:0]    uflow_evt,
  input logic [NUM_Q-1:0]    flags,
  input logic [NUM_Q-1:0]    clr_mask
);
  for (genvar i = 0; i < NUM_Q; i++) begin : g_a
    // R3
    uflow_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req[i] && empty[i]) |=> flags[i]);
    // R4
    uflow_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uflow_evt[i] |=> (pop_data[i*DW +: DW] == '0));
    // R5
    uflow_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uflow_evt[i] && !push_valid[i]) |=> empty[i]);
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_mask[i]) |=> flags[i]);
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[i] && !uflow_evt[i]) |=> !flags[i]);
    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full[i] && empty[i]));
  end

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata >> NUM_Q) == 32'd0);
endmodule

bind smp_uflow_top smp_uflow_chk #(.NUM_Q(NUM_Q), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .push_valid(push_valid),
  .pop_req   (pop_req),
  .pop_data  (pop_data),
  .full      (full),
  .empty     (empty),
  .reg_rdata (reg_rdata),
  .uflow_evt (uflow_evt),
  .flags     (stat_flags),
  .clr_mask  (clr_mask)
);

// File: tb/test_smp_uflow_top.sv
module test_smp_uflow_top;
  localparam int NQ = 4;
  localparam int D  = 8;
  localparam int W  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NQ-1:0] push_valid = '0;
  logic [NQ*W-1:0] push_data = '0;
  logic [NQ-1:0] pop_req = '0;
  logic [NQ*W-1:0] pop_data;
  logic [NQ-1:0] full, empty;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;

  always #5 clk = ~clk;

  smp_uflow_top i_smp_uflow_top (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop_req(pop_req), .pop_data(pop_data), .full(full), .empty(empty),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] mq [NQ][D];
  int rdp [NQ];
  int wrp [NQ];
  int cnt [NQ];
  logic [NQ-1:0] mflags = '0;
  logic [W-1:0]  exp_pd [NQ];
  logic [31:0]   exp_rd = '0;
  string prev_tag = "R10";

  function automatic logic [NQ-1:0] next_flags(logic [NQ-1:0] f, logic [NQ-1:0] uf,
                                               logic [NQ-1:0] clr);
    logic [NQ-1:0] r;
    for (int b = 0; b < NQ; b++) begin
      if (uf[b])       r[b] = 1'b1;
      else if (clr[b]) r[b] = 1'b0;
      else             r[b] = f[b];
    end
    return r;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-BANK FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    for (int q = 0; q < NQ; q++) begin
      check(prev_tag, $sformatf("pop_data[%0d]", q), 32'(pop_data[q*W +: W]), 32'(exp_pd[q]));
      check(prev_tag, $sformatf("full[%0d]", q), 32'(full[q]), 32'(cnt[q] == D));
      check(prev_tag, $sformatf("empty[%0d]", q), 32'(empty[q]), 32'(cnt[q] == 0));
    end
    check(prev_tag, "reg_rdata", reg_rdata, exp_rd);
  endtask

  task automatic step(string tag, logic [NQ-1:0] pv, logic [NQ-1:0] pr,
                      logic [3:0] ad, logic w, logic [31:0] wd);
    logic [NQ-1:0] uf;
    logic [NQ-1:0] clr;
    check_outputs();
    push_valid = pv; pop_req = pr; reg_addr = ad; reg_wr = w; reg_wdata = wd;
    exp_rd = (ad == 4'd0) ? {28'd0, mflags} : 32'd0;
    clr = (w && ad == 4'd0) ? wd[NQ-1:0] : '0;
    uf = '0;
    for (int q = 0; q < NQ; q++) begin
      int c;
      logic [W-1:0] d;
      d = W'($urandom % 1024);
      push_data[q*W +: W] = d;
      c = cnt[q];
      if (pr[q]) begin
        if (c == 0) begin
          uf[q] = 1'b1;
          exp_pd[q] = '0;
        end else begin
          exp_pd[q] = mq[q][rdp[q]];
          rdp[q] = (rdp[q] + 1) % D;
          cnt[q]--;
        end
      end
      if (pv[q] && c < D) begin
        mq[q][wrp[q]] = d;
        wrp[q] = (wrp[q] + 1) % D;
        cnt[q]++;
      end
    end
    mflags = next_flags(mflags, uf, clr);
    prev_tag = tag;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FIFO-BANK FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int q = 0; q < NQ; q++) begin
      rdp[q] = 0; wrp[q] = 0; cnt[q] = 0; exp_pd[q] = '0;
    end
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset values checked by first step
    step("R11", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R3: pop an empty FIFO 2
    step("R3", 4'h0, 4'b0100, 4'd0, 1'b0, 32'd0);
    step("R3", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R4: underflow on FIFO 0 with zero data
    step("R4", 4'h0, 4'b0001, 4'd0, 1'b0, 32'd0);
    // R5: data after an underflow still in order
    for (int k = 0; k < 3; k++) step("R5", 4'b0100, 4'h0, 4'd0, 1'b0, 32'd0);
    for (int k = 0; k < 3; k++) step("R5", 4'h0, 4'b0100, 4'd0, 1'b0, 32'd0);
    // R5: underflow with simultaneous push
    step("R5", 4'b0100, 4'b0100, 4'd0, 1'b0, 32'd0);
    step("R5", 4'h0, 4'b0100, 4'd0, 1'b0, 32'd0);
    // R6: flag survives normal pops and repeated underflows
    step("R6", 4'b0100, 4'b0100, 4'd0, 1'b0, 32'd0);
    step("R6", 4'h0, 4'b0100, 4'd0, 1'b0, 32'd0);
    step("R6", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R7: write of zeros leaves flags, write of one clears bit 2 only
    step("R7", 4'h0, 4'h0, 4'd0, 1'b1, 32'd0);
    step("R7", 4'h0, 4'h0, 4'd0, 1'b1, 32'h4);
    step("R7", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R8: set and clear on FIFO 1 together
    step("R8", 4'h0, 4'b0010, 4'd0, 1'b1, 32'h2);
    step("R8", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R9: reserved bits, other addresses
    step("R9", 4'h0, 4'h0, 4'd0, 1'b1, 32'hFFFF_FFF0);
    step("R9", 4'h0, 4'h0, 4'd5, 1'b1, 32'hFFFF_FFFF);
    step("R9", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    // R2: overfill FIFO 3, then pop and push at full
    for (int k = 0; k < D + 2; k++) step("R2", 4'b1000, 4'h0, 4'd0, 1'b0, 32'd0);
    step("R2", 4'b1000, 4'b1000, 4'd0, 1'b0, 32'd0);
    for (int k = 0; k < D; k++) step("R2", 4'h0, 4'b1000, 4'd0, 1'b0, 32'd0);
    // R1: constrained random traffic
    for (int k = 0; k < 800; k++) begin
      logic [3:0] ad;
      logic w;
      ad = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      w  = ($urandom % 10 == 0);
      step("R1", 4'($urandom & $urandom), 4'($urandom & $urandom), ad, w, $urandom);
    end
    step("R11", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    step("R11", 4'h0, 4'h0, 4'd0, 1'b0, 32'd0);
    check_outputs();
    report();
  end
endmodule